// File: doc/BRIEF.md
# Double-Buffered NRZ Serial Transmitter

This block turns parallel characters into asynchronous NRZ frames on a single output line. A frame is a low start bit, eight or nine data bits sent lowest bit first, and a high stop bit. Characters come in through a one-cycle write strobe and land in a holding register. The transmitter then copies the holding register into a separate shift register, so the next character can be written while the current one is still going out.

An external divider supplies a baud tick strobe, and every bit on the line lasts sixteen of those ticks. An enable input decides whether new frames may start. A frame that has already started always runs to its end. A break request replaces frames with whole frame times of continuous low. Two status outputs report an empty holding register and a fully drained transmitter.

Top module: `nrz_tx_dbuf`

## Requirements
- R1: While reset is high and in the first cycle after it, `txLine` is 1, `holdEmpty` is 1 and `txDone` is 1.
- R2: A data frame is a start bit of 0, then the data bits with bit 0 first, then one stop bit of 1. Each bit lasts exactly 16 asserted `baudTick` cycles.
- R3: When `wideWord` is 0 a frame carries `wrData[7:0]` (10 bit times). When it is 1 the frame carries `wrData[8:0]`, with `wrData[8]` as the last data bit (11 bit times). The value of `wideWord` at frame start is used for the whole frame.
- R4: Whenever no frame or break is in progress, `txLine` is 1, whatever the state of `txEnable`.
- R5: A write (`wrValid` high) stores `wrData` in the holding register, and `holdEmpty` is 0 in the following cycle. A second write before the transfer replaces the first character, and only the second character is sent.
- R6: With the shifter idle, `txEnable` high and a character held, the character moves to the shifter on the next clock. `holdEmpty` is 1 and the start bit is on the line one cycle after the write is seen.
- R7: A character held while a frame is in progress starts in the cycle right after that frame's stop bit ends, with no idle time between the two frames.
- R8: While `txEnable` is 0 no new frame starts and a held character waits. A frame that is in progress when `txEnable` falls finishes normally. Raising `txEnable` again sends the held character.
- R9: `txDone` is 1 exactly when no frame or break is in progress and the holding register is empty.
- R10: With `txEnable` high, `breakReq` high at a frame boundary or while idle starts a break: `txLine` is 0 for one full frame time (10 or 11 bit times). Breaks repeat while `breakReq` stays high, and a break takes precedence over a held character. That character follows directly after the last break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baudTick | input | 1 | One-cycle strobe from the baud divider, 16 per bit |
| txEnable | input | 1 | Allows new frames and breaks to start |
| wideWord | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| breakReq | input | 1 | Requests break frames |
| wrValid | input | 1 | Write strobe for the holding register |
| wrData | input | 9 | Character to send; bit 8 is used only in 9-bit mode |
| txLine | output | 1 | Serial output, idle high |
| holdEmpty | output | 1 | Holding register can take a new character |
| txDone | output | 1 | Shifter idle and holding register empty |

## Verification
The holding flag reacts one clock after the write strobe, and the transfer to the shifter comes one clock after that. The bench therefore reads `holdEmpty` and the start bit at the falling edges that follow those two rising edges. Line bits are not timed in clock cycles. The bench counts the baud ticks it presents, and the DUT consumes each tick at the next rising edge, so the bench samples each bit at the falling edge where its eighth tick is visible. This keeps the checks valid under the tick rates of one, two or three cycles that the bench picks at random. For frames that must follow without a gap, the bench requires the line to be low at the first falling edge after the previous frame's final tick.

// File: rtl/nrz_tx_pkg.sv
package nrz_tx_pkg;

  // Strobes from the control side to the datapath.
  typedef struct packed {
    logic loadData;  // copy holding register into shifter, start bit on line
    logic shiftBit;  // advance shifter by one bit
  } txStrobe_t;

endpackage

// File: rtl/nrz_tx_ctrl.sv
module nrz_tx_ctrl
  import nrz_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int FRAME_MAX     = 11
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      baudTick,
  input  logic      txEnable,
  input  logic      wideWord,
  input  logic      breakReq,
  input  logic      holdFull,
  output txStrobe_t strobe,
  output logic      busy,
  output logic      brkMode
);

  localparam int TICK_W = $clog2(TICKS_PER_BIT);
  localparam int IDX_W  = $clog2(FRAME_MAX + 1);

  logic [TICK_W-1:0] tickCnt;
  logic [IDX_W-1:0]  bitIdx;
  logic [IDX_W-1:0]  curLen;

  logic bitEnd, lastBit, frameEnd, canStart, startBrk, startData;

  always_comb begin
    bitEnd    = busy && baudTick && (tickCnt == TICK_W'(TICKS_PER_BIT - 1));
    lastBit   = (bitIdx == curLen - IDX_W'(1));
    frameEnd  = bitEnd && lastBit;
    canStart  = txEnable && (!busy || frameEnd);
    startBrk  = canStart && breakReq;
    startData = canStart && !breakReq && holdFull;
    strobe.loadData = startData;
    strobe.shiftBit = bitEnd && !lastBit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      brkMode <= 1'b0;
      tickCnt <= '0;
      bitIdx  <= '0;
      curLen  <= IDX_W'(FRAME_MAX - 1);
    end else if (startBrk || startData) begin
      busy    <= 1'b1;
      brkMode <= startBrk;
      tickCnt <= '0;
      bitIdx  <= '0;
      curLen  <= wideWord ? IDX_W'(FRAME_MAX) : IDX_W'(FRAME_MAX - 1);
    end else if (frameEnd) begin
      busy    <= 1'b0;
      brkMode <= 1'b0;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (bitEnd) begin
      tickCnt <= '0;
      bitIdx  <= bitIdx + IDX_W'(1);
    end else if (busy && baudTick) begin
      tickCnt <= tickCnt + TICK_W'(1);
    end
  end

  // R8: a frame only begins if enable was high in the deciding cycle
  a_r8_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(txEnable));

  // R8: an idle, disabled transmitter stays idle
  a_r8_no_start_disabled: assert property (@(posedge clk) disable iff (rst)
    (!busy && !txEnable) |=> !busy);

  // R2: bit position never runs past the frame length
  a_r2_index_in_frame: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bitIdx < curLen));

endmodule

// File: rtl/nrz_tx_path.sv
module nrz_tx_path
  import nrz_tx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wideWord,
  input  txStrobe_t         strobe,
  input  logic              busy,
  input  logic              brkMode,
  output logic              txLine,
  output logic              holdFull
);

  localparam int SHIFT_W = DATA_W + 2;

  logic [DATA_W-1:0]  holdData;
  logic [SHIFT_W-1:0] shiftReg;

  // Holding register: a write always wins over the transfer's clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      holdFull <= 1'b0;
      holdData <= '0;
    end else begin
      if (wrValid) holdData <= wrData;
      if (wrValid)              holdFull <= 1'b1;
      else if (strobe.loadData) holdFull <= 1'b0;
    end
  end

  // Shifter: stop | top data bit or extra stop | low data bits | start
  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '1;
    end else if (strobe.loadData) begin
      shiftReg <= {1'b1, (wideWord ? holdData[DATA_W-1] : 1'b1),
                   holdData[DATA_W-2:0], 1'b0};
    end else if (strobe.shiftBit) begin
      shiftReg <= {1'b1, shiftReg[SHIFT_W-1:1]};
    end
  end

  always_comb begin
    if (!busy)        txLine = 1'b1;
    else if (brkMode) txLine = 1'b0;
    else              txLine = shiftReg[0];
  end

  // R2: a transfer puts the start bit on the line in the next cycle
  a_r2_start_bit_low: assert property (@(posedge clk) disable iff (rst)
    strobe.loadData |=> !txLine);

  // R5: a write always leaves the holding register occupied
  a_r5_write_marks_full: assert property (@(posedge clk) disable iff (rst)
    wrValid |=> holdFull);

endmodule

// File: rtl/nrz_tx_dbuf.sv
module nrz_tx_dbuf
  import nrz_tx_pkg::*;
#(
  parameter int DATA_W        = 9,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baudTick,
  input  logic              txEnable,
  input  logic              wideWord,
  input  logic              breakReq,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  output logic              txLine,
  output logic              holdEmpty,
  output logic              txDone
);

  localparam int FRAME_MAX = DATA_W + 2;

  txStrobe_t strobe;
  logic busy, brkMode, holdFull;

  nrz_tx_ctrl #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .FRAME_MAX    (FRAME_MAX)
  ) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .baudTick(baudTick),
    .txEnable(txEnable),
    .wideWord(wideWord),
    .breakReq(breakReq),
    .holdFull(holdFull),
    .strobe  (strobe),
    .busy    (busy),
    .brkMode (brkMode)
  );

  nrz_tx_path #(
    .DATA_W(DATA_W)
  ) uPath (
    .clk     (clk),
    .rst     (rst),
    .wrValid (wrValid),
    .wrData  (wrData),
    .wideWord(wideWord),
    .strobe  (strobe),
    .busy    (busy),
    .brkMode (brkMode),
    .txLine  (txLine),
    .holdFull(holdFull)
  );

  assign holdEmpty = !holdFull;
  assign txDone    = !busy && !holdFull;

  // R9: a drained transmitter shows the idle level
  a_r9_done_means_idle: assert property (@(posedge clk) disable iff (rst)
    txDone |-> txLine);

endmodule

// File: tb/tb_nrz_tx_dbuf.sv
`timescale 1ns/1ps
module tb_nrz_tx_dbuf;

  logic clk = 1'b0;
  logic rst, baudTick, txEnable, wideWord, breakReq, wrValid;
  logic [8:0] wrData;
  logic txLine, holdEmpty, txDone;

  int nChecks = 0;
  int nFails  = 0;
  int tickDiv = 1;
  int divCnt  = 0;
  bit summaryDone = 0;

  always #2 clk = ~clk;

  nrz_tx_dbuf dut (
    .clk(clk), .rst(rst), .baudTick(baudTick), .txEnable(txEnable),
    .wideWord(wideWord), .breakReq(breakReq), .wrValid(wrValid),
    .wrData(wrData), .txLine(txLine), .holdEmpty(holdEmpty), .txDone(txDone)
  );

  // Baud strobe source: one tick every tickDiv cycles.
  always @(negedge clk) begin
    if (divCnt >= tickDiv - 1) divCnt <= 0;
    else                       divCnt <= divCnt + 1;
    baudTick <= (divCnt >= tickDiv - 1);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic frameBit(input logic [8:0] d, input bit nine,
                                    input int k, input bit brk);
    if (brk)                 return 1'b0;
    if (k == 0)              return 1'b0;
    if (k <= (nine ? 9 : 8)) return d[k-1];
    return 1'b1;
  endfunction

  task automatic smp();
    @(negedge clk);
    #1;
  endtask

  task automatic writeChar(input logic [8:0] d);
    @(negedge clk);
    wrValid = 1'b1;
    wrData  = d;
    @(negedge clk);
    wrValid = 1'b0;
    #1;
  endtask

  // Decodes one frame (or break) by counting visible baud ticks.
  task automatic expectFrame(input logic [8:0] d, input bit nine, input bit brk,
                             input bit chained, input string req);
    int len;
    int seen;
    logic [10:0] got;
    logic [10:0] exp;
    len  = nine ? 11 : 10;
    seen = 0;
    got  = '0;
    exp  = '0;
    if (chained) begin
      smp();
      check(txLine === 1'b0, req, "frame start directly after previous", txLine, 0);
    end else begin
      smp();
      while (txLine !== 1'b0) smp();
    end
    while (seen < 16 * len) begin
      if (baudTick) begin
        seen++;
        if (seen % 16 == 8) got[seen/16] = txLine;
      end
      if (seen < 16 * len) smp();
    end
    for (int k = 0; k < len; k++) exp[k] = frameBit(d, nine, k, brk);
    check(got === exp, req, brk ? "break line bits" : "frame bits",
          int'(got), int'(exp));
  endtask

  task automatic expectIdle(input int cycles, input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < cycles; i++) begin
      smp();
      if (txLine !== 1'b1) bad++;
    end
    check(bad == 0, req, "line stays idle high (low cycles)", bad, 0);
  endtask

  initial begin
    #(4 * 190000);
    if (!summaryDone) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      summaryDone = 1;
      $finish;
    end
  end

  initial begin
    int unsigned seedVal;
    seedVal  = $urandom(32'h0005EED7);
    rst      = 1'b1;
    txEnable = 1'b0;
    wideWord = 1'b0;
    breakReq = 1'b0;
    wrValid  = 1'b0;
    wrData   = '0;
    baudTick = 1'b0;
    repeat (3) smp();
    check(txLine === 1'b1, "R1", "txLine in reset", txLine, 1);
    @(negedge clk);
    rst = 1'b0;
    #1;
    smp();
    check(txLine === 1'b1,    "R1", "txLine after reset", txLine, 1);
    check(holdEmpty === 1'b1, "R1", "holdEmpty after reset", holdEmpty, 1);
    check(txDone === 1'b1,    "R1", "txDone after reset", txDone, 1);

    // R2 R5 R6 R9: single 8-bit frame from idle
    txEnable = 1'b1;
    fork
      expectFrame(9'h0A5, 1'b0, 1'b0, 1'b0, "R2");
      begin
        writeChar(9'h0A5);
        check(holdEmpty === 1'b0, "R5", "holdEmpty after write", holdEmpty, 0);
        smp();
        check(holdEmpty === 1'b1, "R6", "holdEmpty after transfer", holdEmpty, 1);
        check(txLine === 1'b0,    "R6", "start bit after transfer", txLine, 0);
        check(txDone === 1'b0,    "R9", "txDone while sending", txDone, 0);
      end
    join
    smp();
    check(txDone === 1'b1, "R9", "txDone after frame", txDone, 1);
    expectIdle(40, "R4");

    // R3: 9-bit frames; flipping wideWord mid-frame has no effect
    wideWord = 1'b1;
    fork
      expectFrame(9'h13C, 1'b1, 1'b0, 1'b0, "R3");
      begin
        writeChar(9'h13C);
        repeat (40) smp();
        wideWord = 1'b0;
      end
    join
    tickDiv  = 2;
    wideWord = 1'b1;
    fork
      expectFrame(9'h0C3, 1'b1, 1'b0, 1'b0, "R3");
      writeChar(9'h0C3);
    join
    tickDiv  = 1;
    wideWord = 1'b0;
    expectIdle(20, "R4");

    // R7: back-to-back frames through the holding register
    fork
      begin
        expectFrame(9'h0E1, 1'b0, 1'b0, 1'b0, "R7");
        expectFrame(9'h01E, 1'b0, 1'b0, 1'b1, "R7");
      end
      begin
        writeChar(9'h0E1);
        while (holdEmpty !== 1'b1) smp();
        writeChar(9'h01E);
        check(holdEmpty === 1'b0, "R5", "second char held while shifting", holdEmpty, 0);
      end
    join
    expectIdle(20, "R4");

    // R5 R8 R9: overwrite while disabled
    txEnable = 1'b0;
    writeChar(9'h011);
    writeChar(9'h03E);
    expectIdle(100, "R8");
    check(holdEmpty === 1'b0, "R8", "char waits while disabled", holdEmpty, 0);
    check(txDone === 1'b0,    "R9", "txDone with char held", txDone, 0);
    txEnable = 1'b1;
    expectFrame(9'h03E, 1'b0, 1'b0, 1'b0, "R5");
    expectIdle(400, "R5");
    check(holdEmpty === 1'b1, "R5", "nothing left after overwrite", holdEmpty, 1);

    // R8: disable mid-frame; frame finishes, held char waits
    fork
      expectFrame(9'h05A, 1'b0, 1'b0, 1'b0, "R8");
      begin
        writeChar(9'h05A);
        smp();
        writeChar(9'h077);
        repeat (20) smp();
        txEnable = 1'b0;
      end
    join
    expectIdle(500, "R8");
    check(holdEmpty === 1'b0, "R8", "held char kept while disabled", holdEmpty, 0);
    txEnable = 1'b1;
    expectFrame(9'h077, 1'b0, 1'b0, 1'b0, "R8");

    // R10: break takes precedence over a held char, which then follows
    expectIdle(20, "R4");
    fork
      begin
        expectFrame(9'h000, 1'b0, 1'b1, 1'b0, "R10");
        expectFrame(9'h069, 1'b0, 1'b0, 1'b1, "R10");
      end
      begin
        @(negedge clk);
        breakReq = 1'b1;
        wrValid  = 1'b1;
        wrData   = 9'h069;
        @(negedge clk);
        wrValid  = 1'b0;
        #1;
        check(holdEmpty === 1'b0, "R10", "char held during break", holdEmpty, 0);
        repeat (30) smp();
        breakReq = 1'b0;
      end
    join

    // R10: two consecutive 9-bit breaks while request held
    wideWord = 1'b1;
    smp();
    fork
      begin
        expectFrame(9'h000, 1'b1, 1'b1, 1'b0, "R10");
        expectFrame(9'h000, 1'b1, 1'b1, 1'b1, "R10");
      end
      begin
        @(negedge clk);
        breakReq = 1'b1;
        repeat (200) smp();
        breakReq = 1'b0;
      end
    join
    smp();
    check(txLine === 1'b1, "R4", "idle after breaks", txLine, 1);

    // R2 R3: random characters, widths and tick rates
    for (int i = 0; i < 8; i++) begin
      logic [8:0] d;
      bit nine;
      tickDiv  = 1 + int'($urandom % 3);
      nine     = bit'($urandom % 2);
      d        = 9'($urandom % 512);
      wideWord = nine;
      fork
        expectFrame(d, nine, 1'b0, 1'b0, nine ? "R3" : "R2");
        writeChar(d);
      join
      repeat (1 + int'($urandom % 20)) smp();
    end
    smp();
    check(txDone === 1'b1, "R9", "txDone at end", txDone, 1);

    if (!summaryDone) begin
      summaryDone = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule